// File: doc/BRIEF.md
# Power-Good Window Monitor

This block decides, for one regulator channel, whether the power-good indication may be released. It takes three comparator flags: output above the upper window edge, output below the lower window edge, and output at or above ninety percent of target. It also takes a flag from the start-up supervisor that says soft-start has finished, and a channel enable. It drives a single pull-down enable for an open-drain power-good pin. A value of 1 means the pin is pulled low, which signals that power is not good.

The window edges sit ten percent above and ten percent below the target. While the channel is still starting up, the indication stays low until soft-start has finished and the output has also reached ninety percent of target. Once power good has been released for the first time, only the two window flags matter.

Every change of the indication in either direction has to be qualified. The raw condition must differ from the current indication for `QUAL_CYCLES` consecutive clocks; at a 50 MHz clock the default of 250 clocks is 5 µs. If the raw condition agrees with the indication again before that time is up, the qualification count starts over. Each channel uses its own instance, so a fault in one channel does not affect another.

Top module: `pgood_window_monitor`

## Requirements
- R1: After reset, `pg_pull_low` is 1. It stays 1 until a good condition has been qualified.
- R2: While `en` is 1, the good condition is: `ss_done`=1, `over_win`=0, `under_win`=0, and (on first start-up) `at_ninety`=1. When this condition holds continuously, `pg_pull_low` falls to 0 on the `QUAL_CYCLES`-th rising edge. After `QUAL_CYCLES`-1 edges it is still 1.
- R3: While `ss_done` is 0, power good is never released, whatever the other flags are.
- R4: Before the first release after reset or enable, power good is not released while `at_ninety` is 0.
- R5: After the first release, `at_ninety` going to 0 has no effect on `pg_pull_low` while the output stays inside the window.
- R6: If `over_win` is 1 for `QUAL_CYCLES` consecutive edges, `pg_pull_low` becomes 1 on the last of those edges.
- R7: If `under_win` is 1 for `QUAL_CYCLES` consecutive edges, `pg_pull_low` becomes 1 on the last of those edges.
- R8: Suppose a raw condition that differs from the current indication lasts fewer than `QUAL_CYCLES` edges. Then `pg_pull_low` does not change, and the qualification count restarts from zero.
- R9: After a window fault, the indication is released again once the output has been back inside the window for `QUAL_CYCLES` edges. `at_ninety` is not needed for this.
- R10: When `en` is 0, `pg_pull_low` is 1 from the next clock edge on. The start-up gating of R4 applies again after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Channel enable |
| over_win | input | 1 | Output is above the upper window edge (+10%) |
| under_win | input | 1 | Output is below the lower window edge (-10%) |
| at_ninety | input | 1 | Output has reached 90% of target |
| ss_done | input | 1 | Soft-start has finished |
| pg_pull_low | output | 1 | 1 = pull the power-good pin low (not good) |

## Verification
The assertions assume that the comparator flags are synchronous to `clk` and only change between edges. They also assume that `ss_done` stays high for as long as the channel is meant to run. The bench drives every input just after a falling edge. In its random phase it holds each flag pattern for a random number of cycles, some shorter and some longer than the qualification time. It also drops `en` from time to time, so the start-up gating is exercised many times over.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  // Width of a counter that must reach n-1
  function automatic int unsigned pgm_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pgm_condition.sv
module pgm_condition (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic over_win,
  input  logic under_win,
  input  logic at_ninety,
  input  logic ss_done,
  input  logic qual_good,
  output logic cand_good
);
  logic started_q, started_d;
  logic start_ok;

  always_comb begin
    started_d = started_q;
    if (!en)            started_d = 1'b0;
    else if (qual_good) started_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= started_d;
  end

  always_comb begin
    start_ok  = started_q | at_ninety;
    cand_good = en & ss_done & ~over_win & ~under_win & start_ok;
  end

`ifndef SYNTHESIS
  // R10
  en_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !started_q);
`endif
endmodule

// File: rtl/pgm_deglitch.sv
module pgm_deglitch #(
  parameter int unsigned QUAL_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic raw_good,
  output logic qual_good
);
  import pgm_pkg::*;
  localparam int unsigned CW = pgm_cnt_w(QUAL_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          good_q, good_d;
  logic          differ;

  always_comb begin
    differ = raw_good ^ good_q;
    cnt_d  = cnt_q;
    good_d = good_q;
    if (!en) begin
      cnt_d  = '0;
      good_d = 1'b0;
    end else if (!differ) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      good_d = raw_good;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
    end
  end

  assign qual_good = good_q;

`ifndef SYNTHESIS
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8
  flip_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_q != $past(good_q)) && $past(en) |-> $past(cnt_q) == LAST);
`endif
endmodule

// File: rtl/pgood_window_monitor.sv
module pgood_window_monitor #(
  parameter int unsigned QUAL_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic over_win,
  input  logic under_win,
  input  logic at_ninety,
  input  logic ss_done,
  output logic pg_pull_low
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cand_good;
  logic       qual_good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pgm_condition u_cond (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (en),
    .over_win  (over_win),
    .under_win (under_win),
    .at_ninety (at_ninety),
    .ss_done   (ss_done),
    .qual_good (qual_good),
    .cand_good (cand_good)
  );

  pgm_deglitch #(.QUAL_CYCLES(QUAL_CYCLES)) u_dg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (en),
    .raw_good  (cand_good),
    .qual_good (qual_good)
  );

  assign pg_pull_low = ~qual_good;

`ifndef SYNTHESIS
  // R10
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en |=> pg_pull_low);
  // R3
  ss_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(pg_pull_low) |-> $past(ss_done));
  // R6
  ov_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(pg_pull_low) |-> !$past(over_win));
  // R7
  uv_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(pg_pull_low) |-> !$past(under_win));
  // R1
  rst_state_chk: assert property (@(posedge clk)
    !$past(rst_int_n) |-> pg_pull_low);
`endif
endmodule

// File: tb/sim_pgood_window_monitor.sv
module sim_pgood_window_monitor;
  localparam int unsigned Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ovw = 1'b0, uvw = 1'b0, a90 = 1'b0, ssd = 1'b0;
  logic pd;

  int n_cmp = 0;
  int n_bad = 0;
  bit model_on = 1'b0;

  logic m_good, m_started;
  int   m_cnt;

  always #10 clk = ~clk; // 50 MHz

  pgood_window_monitor #(.QUAL_CYCLES(Q)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .over_win(ovw), .under_win(uvw),
    .at_ninety(a90), .ss_done(ssd), .pg_pull_low(pd)
  );

  function automatic bit cand(input bit e, input bit s, input bit o,
                              input bit u, input bit n, input bit st);
    return e && s && !o && !u && (st || n);
  endfunction

  // Reference model of the requirement set
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_good <= 1'b0; m_started <= 1'b0; m_cnt <= 0;
    end else if (!en) begin
      m_good <= 1'b0; m_started <= 1'b0; m_cnt <= 0;
    end else begin
      if (m_good) m_started <= 1'b1;
      if (cand(en, ssd, ovw, uvw, a90, m_started) != m_good) begin
        if (m_cnt == int'(Q) - 1) begin
          m_good <= ~m_good; m_cnt <= 0;
        end else m_cnt <= m_cnt + 1;
      end else m_cnt <= 0;
    end
  end

  task automatic chk(input string req, input logic exp);
    n_cmp++;
    if (pd !== exp) begin
      n_bad++;
      $display("FAIL %s: pg_pull_low=%b expected=%b at %0t", req, pd, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) chk("R2 R6 R7 R8 R9 R10 model", ~m_good);

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv(input bit e, input bit s, input bit o, input bit u, input bit n);
    en = e; ssd = s; ovw = o; uvw = u; a90 = n;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    w(3); rst_n = 1'b1; w(5);
    chk("R1", 1'b1);
    model_on = 1'b1;

    // R2: exact qualification time
    drv(1, 1, 0, 0, 1); w(Q - 1); chk("R2", 1'b1); w(1); chk("R2", 1'b0);

    // R5: at_ninety drop ignored after release
    drv(1, 1, 0, 0, 0); w(3 * Q); chk("R5", 1'b0);

    // R8: glitch shorter than Q, then restart of count
    drv(1, 1, 1, 0, 0); w(Q - 1); drv(1, 1, 0, 0, 0); w(1);
    drv(1, 1, 1, 0, 0); w(Q - 1); chk("R8", 1'b0); w(1); chk("R6", 1'b1);

    // R9: return to window without at_ninety
    drv(1, 1, 0, 0, 0); w(Q - 1); chk("R9", 1'b1); w(1); chk("R9", 1'b0);

    // R7: undervoltage
    drv(1, 1, 0, 1, 1); w(Q - 1); chk("R7", 1'b0); w(1); chk("R7", 1'b1);
    drv(1, 1, 0, 0, 1); w(Q + 1); chk("R9", 1'b0);

    // R10: disable pulls low on next edge and re-arms
    drv(0, 1, 0, 0, 1); w(1); chk("R10", 1'b1);
    drv(1, 1, 0, 0, 0); w(3 * Q); chk("R10", 1'b1); chk("R4", 1'b1);
    drv(1, 1, 0, 0, 1); w(Q); chk("R4", 1'b0);

    // R3: no soft-start done, never released
    drv(0, 0, 0, 0, 1); w(2);
    drv(1, 0, 0, 0, 1); w(3 * Q); chk("R3", 1'b1);
    drv(1, 1, 0, 0, 1); w(Q); chk("R3", 1'b0);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0; w(1); chk("R1", 1'b1); drv(0, 0, 0, 0, 0);
    rst_n = 1'b1; w(4);

    // Random phase
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 99);
      drv(r > 5, $urandom_range(0, 9) > 1, $urandom_range(0, 9) == 0,
          $urandom_range(0, 9) == 0, $urandom_range(0, 3) != 0);
      w($urandom_range(1, 2 * Q));
    end

    model_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule